// File: doc/BRIEF.md
# Ethernet PHY Link Qualification Monitor

This block decides whether a 10/100 Ethernet PHY link is up, and at which speed, from simplified receive-side indications. It sees a descrambler-lock flag, a per-cycle idle-symbol strobe, a normal-link-pulse strobe, the transmit-enable and receive-data-valid activity lines, and the two half-duplex abilities the local side advertises. From these it reports link-up, the resolved speed, the resolved duplex and a sticky "result received" bit that clears when read.

At 100 Mbps the lock must hold without a break for a programmable qualification time. After that the idle-symbol stream is policed window by window. At 10 Mbps a filtered pulse detection is followed by a wait for a moment when neither direction carries a frame. Every resolution is a parallel-detection result, so it is always half duplex, and it is refused when the matching half-duplex ability is not advertised. All intervals are given as clock-cycle counts, so the real millisecond figures become parameter values.

Top module: `phy_link_qual`

## Requirements
- R1: While `rst` is high, and after it, until a qualification completes, `link_up_o`, `speed100_o`, `half_duplex_o` and `page_rcvd_o` are all 0.
- R2: With `adv_hd100_i`=1, starting from link down, `link_up_o` and `speed100_o` become 1 right after the clock edge that samples `lock_i` high for the (LOCK_CYCLES+1)-th consecutive time. They are still 0 one edge earlier.
- R3: A single low cycle of `lock_i` during qualification returns the block to link down, and the full lock count starts again from zero.
- R4: Once up at 100 Mbps, time is cut into windows of WIN_CYCLES cycles that start with the first linked cycle. If a window holds no run of MIN_IDLE_RUN consecutive cycles with `idle_sym_i`=1 (a run does not carry over a window boundary), the link drops right after that window's last edge.
- R5: With `adv_hd10_i`=1, after NLP_PERSIST consecutive cycles of `nlp_i`=1 in link down, the block waits. It brings up a 10 Mbps link (`link_up_o`=1, `speed100_o`=0) right after the first edge that samples `tx_en_i`=0 and `rx_dv_i`=0 together.
- R6: Bursts of `nlp_i` shorter than NLP_PERSIST cycles never start the 10 Mbps path.
- R7: Every established link reports `half_duplex_o`=1. Lock is ignored while `adv_hd100_i`=0, and link pulses are ignored while `adv_hd10_i`=0.
- R8: `page_rcvd_o` is set on the edge that brings the link up. It stays set until a cycle with `status_rd_i`=1, which clears it on the following edge.
- R9: After any link drop, `link_up_o` stays 0 for at least one cycle before a new link can appear.
- R10: `an_restart_i`=1 forces link down and clears `page_rcvd_o` on the next edge, with priority over every other event.
- R11: When `lock_i` and a completed pulse filter coincide in link down, the 100 Mbps qualification is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_i | input | 1 | Descrambler locked |
| idle_sym_i | input | 1 | Idle symbol seen this cycle |
| nlp_i | input | 1 | Normal link pulse detected this cycle |
| tx_en_i | input | 1 | Transmit activity |
| rx_dv_i | input | 1 | Receive activity |
| adv_hd100_i | input | 1 | Local 100 Mbps half-duplex ability advertised |
| adv_hd10_i | input | 1 | Local 10 Mbps half-duplex ability advertised |
| an_restart_i | input | 1 | New negotiation starts |
| status_rd_i | input | 1 | Status read strobe, clears the sticky bit |
| link_up_o | output | 1 | Link established |
| speed100_o | output | 1 | 1 = 100 Mbps, 0 = 10 Mbps (valid with link) |
| half_duplex_o | output | 1 | Resolved half duplex (valid with link) |
| page_rcvd_o | output | 1 | Sticky result-received status |

## Verification
The bench breaks the lock a few cycles before qualification would complete. A design that failed to restart its count would come up too early. It drives idle runs one symbol short of the threshold, and runs exactly at the threshold. An off-by-one window check would either keep a noisy link or drop a clean one. The 10 Mbps path is tested with pulse bursts one cycle short of the filter and with activity that ends one direction at a time. A design that ignored either activity line would link up in the middle of a frame. Sticky-bit clearing, the priority of a restart, and the one-cycle down gap after a drop are compared every cycle against a behavioural model.

// File: rtl/plq_pkg.sv
package plq_pkg;
  typedef enum logic [2:0] {
    LINK_DOWN,
    QUAL_100,
    QUAL_10_WAIT_IDLE,
    LINK_UP_100,
    LINK_UP_10
  } plq_state_e;
endpackage

// File: rtl/plq_persist_cnt.sv
// Counts consecutive cycles with en_i high; done_o marks the N-th one.
module plq_persist_cnt #(
  parameter int N = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic done_o
);
  localparam int W = $clog2(N + 1);
  localparam logic [W-1:0] LAST = W'(N - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en_i) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done_o = en_i && (cnt == LAST);

  // R3/R6: a fresh run always starts counting from zero
  assert_run_restarts_R3: assert property (@(posedge clk) disable iff (rst)
    (en_i && !$past(en_i)) |-> (cnt == '0));
endmodule

// File: rtl/plq_idle_window.sv
// Per-window check that a run of MIN_RUN consecutive idle symbols occurred.
module plq_idle_window #(
  parameter int WIN_CYCLES = 64,
  parameter int MIN_RUN    = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic idle_i,
  output logic fail_o
);
  localparam int WW = $clog2(WIN_CYCLES + 1);
  localparam int RW = $clog2(MIN_RUN + 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_CYCLES - 1);
  localparam logic [RW-1:0] RUN_LAST = RW'(MIN_RUN - 1);

  logic [WW-1:0] win_cnt;
  logic [RW-1:0] run;
  logic          met;
  logic          win_end;
  logic          hit;

  assign win_end = en_i && (win_cnt == WIN_LAST);
  assign hit     = idle_i && (run >= RUN_LAST);

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      win_cnt <= '0;
      run     <= '0;
      met     <= 1'b0;
    end else if (win_end) begin
      win_cnt <= '0;
      run     <= '0;
      met     <= 1'b0;
    end else begin
      win_cnt <= win_cnt + 1'b1;
      if (!idle_i)             run <= '0;
      else if (run != RUN_LAST) run <= run + 1'b1;
      met <= met | hit;
    end
  end

  assign fail_o = win_end && !(met || hit);

  // R4: a run never survives into the next window
  assert_run_reset_at_edge_R4: assert property (@(posedge clk) disable iff (rst)
    $past(win_end) |-> (run == '0 && !met));
endmodule

// File: rtl/phy_link_qual.sv
module phy_link_qual #(
  parameter int LOCK_CYCLES  = 1000,
  parameter int WIN_CYCLES   = 64,
  parameter int MIN_IDLE_RUN = 16,
  parameter int NLP_PERSIST  = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic lock_i,
  input  logic idle_sym_i,
  input  logic nlp_i,
  input  logic tx_en_i,
  input  logic rx_dv_i,
  input  logic adv_hd100_i,
  input  logic adv_hd10_i,
  input  logic an_restart_i,
  input  logic status_rd_i,
  output logic link_up_o,
  output logic speed100_o,
  output logic half_duplex_o,
  output logic page_rcvd_o
);
  import plq_pkg::*;

  plq_state_e state, state_nx;
  logic lock_done, nlp_done, win_fail;
  logic up_now, up_nx;

  plq_persist_cnt #(.N(LOCK_CYCLES)) u_lock_timer (
    .clk(clk), .rst(rst),
    .en_i(state == QUAL_100 && lock_i),
    .done_o(lock_done)
  );

  plq_persist_cnt #(.N(NLP_PERSIST)) u_nlp_filter (
    .clk(clk), .rst(rst),
    .en_i(state == LINK_DOWN && nlp_i),
    .done_o(nlp_done)
  );

  plq_idle_window #(.WIN_CYCLES(WIN_CYCLES), .MIN_RUN(MIN_IDLE_RUN)) u_idle_win (
    .clk(clk), .rst(rst),
    .en_i(state == LINK_UP_100),
    .idle_i(idle_sym_i),
    .fail_o(win_fail)
  );

  always_comb begin
    state_nx = state;
    if (an_restart_i) begin
      state_nx = LINK_DOWN;
    end else begin
      unique case (state)
        LINK_DOWN: begin
          if (lock_i && adv_hd100_i)      state_nx = QUAL_100;
          else if (nlp_done && adv_hd10_i) state_nx = QUAL_10_WAIT_IDLE;
        end
        QUAL_100: begin
          if (!lock_i)        state_nx = LINK_DOWN;
          else if (lock_done) state_nx = LINK_UP_100;
        end
        QUAL_10_WAIT_IDLE: begin
          if (!tx_en_i && !rx_dv_i) state_nx = LINK_UP_10;
        end
        LINK_UP_100: begin
          if (win_fail) state_nx = LINK_DOWN;
        end
        LINK_UP_10: state_nx = LINK_UP_10;
        default:    state_nx = LINK_DOWN;
      endcase
    end
  end

  assign up_now = (state == LINK_UP_100) || (state == LINK_UP_10);
  assign up_nx  = (state_nx == LINK_UP_100) || (state_nx == LINK_UP_10);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= LINK_DOWN;
      link_up_o     <= 1'b0;
      speed100_o    <= 1'b0;
      half_duplex_o <= 1'b0;
      page_rcvd_o   <= 1'b0;
    end else begin
      state         <= state_nx;
      link_up_o     <= up_nx;
      speed100_o    <= (state_nx == LINK_UP_100);
      half_duplex_o <= up_nx;
      if (an_restart_i)          page_rcvd_o <= 1'b0;
      else if (up_nx && !up_now) page_rcvd_o <= 1'b1;
      else if (status_rd_i)      page_rcvd_o <= 1'b0;
    end
  end

  // R2: a 100 Mbps link appears only while lock is held
  assert_up100_locked_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(speed100_o) |-> $past(lock_i));

  // R4: a 100 Mbps link drops only through the window check or a restart
  assert_drop_on_window_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(speed100_o) && !$past(an_restart_i)) |-> $past(win_fail));

  // R5: a 10 Mbps link never comes up inside a frame
  assert_up10_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(link_up_o) && !speed100_o) |-> $past(!tx_en_i && !rx_dv_i));

  // R8: the sticky bit holds until read or restart
  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(page_rcvd_o) && !$past(status_rd_i) && !$past(an_restart_i)) |-> page_rcvd_o);

  // R9: at least one down cycle after a drop
  assert_down_gap_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(link_up_o) |=> !link_up_o);

  // R10: restart clears link and status
  assert_restart_clears_R10: assert property (@(posedge clk) disable iff (rst)
    $past(an_restart_i) |-> (!link_up_o && !page_rcvd_o));
endmodule

// File: tb/phy_link_qual_tb_top.sv
module phy_link_qual_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int L   = 40;
  localparam int WIN = 64;
  localparam int MIN = 16;
  localparam int NLP = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lock_i = 0, idle_sym_i = 0, nlp_i = 0, tx_en_i = 0, rx_dv_i = 0;
  logic adv_hd100_i = 1, adv_hd10_i = 1, an_restart_i = 0, status_rd_i = 0;
  logic link_up_o, speed100_o, half_duplex_o, page_rcvd_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_link_qual #(.LOCK_CYCLES(L), .WIN_CYCLES(WIN), .MIN_IDLE_RUN(MIN),
                  .NLP_PERSIST(NLP)) dut_i (
    .clk(clk), .rst(rst), .lock_i(lock_i), .idle_sym_i(idle_sym_i), .nlp_i(nlp_i),
    .tx_en_i(tx_en_i), .rx_dv_i(rx_dv_i), .adv_hd100_i(adv_hd100_i),
    .adv_hd10_i(adv_hd10_i), .an_restart_i(an_restart_i), .status_rd_i(status_rd_i),
    .link_up_o(link_up_o), .speed100_o(speed100_o), .half_duplex_o(half_duplex_o),
    .page_rcvd_o(page_rcvd_o)
  );

  // Behavioural reference: 0 down, 1 lock qual, 2 wait quiet, 3 up 100, 4 up 10
  int ms = 0, lock_run = 0, nlp_run = 0, wpos = 0, run = 0;
  bit met = 0, m_page = 0, prev_up;

  always @(posedge clk) begin
    if (rst) begin
      ms = 0; lock_run = 0; nlp_run = 0; wpos = 0; run = 0; met = 0; m_page = 0;
    end else begin
      prev_up = (ms >= 3);
      if (an_restart_i) begin
        ms = 0; lock_run = 0; nlp_run = 0; wpos = 0; run = 0; met = 0; m_page = 0;
      end else begin
        case (ms)
          0: begin
            nlp_run = nlp_i ? nlp_run + 1 : 0;
            if (lock_i && adv_hd100_i) begin ms = 1; lock_run = 0; end
            else if (nlp_run >= NLP && adv_hd10_i) ms = 2;
          end
          1: begin
            if (!lock_i) ms = 0;
            else begin
              lock_run++;
              if (lock_run == L) begin ms = 3; wpos = 0; run = 0; met = 0; end
            end
          end
          2: if (!tx_en_i && !rx_dv_i) ms = 4;
          3: begin
            wpos++;
            run = idle_sym_i ? run + 1 : 0;
            if (run >= MIN) met = 1;
            if (wpos == WIN) begin
              if (!met) ms = 0;
              wpos = 0; run = 0; met = 0;
            end
          end
          default: ;
        endcase
        if (ms != 1) lock_run = 0;
        if (ms != 0) nlp_run = 0;
        if (ms >= 3 && !prev_up) m_page = 1;
        else if (status_rd_i) m_page = 0;
      end
    end
  end

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if ({link_up_o, speed100_o, half_duplex_o, page_rcvd_o} !==
          {ms >= 3, ms == 3, ms >= 3, m_page}) begin
        failures++;
        $display("FAIL %s cycle %0d: act link/s100/half/page=%b%b%b%b exp=%b%b%b%b",
                 cur_req, cyc, link_up_o, speed100_o, half_duplex_o, page_rcvd_o,
                 ms >= 3, ms == 3, ms >= 3, m_page);
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_pattern(input int on, input int off, input int total);
    for (int i = 0; i < total; i++) begin
      idle_sym_i = ((i % (on + off)) < on);
      @(negedge clk);
    end
  endtask

  task automatic restart;
    an_restart_i = 1; cycles(1); an_restart_i = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cycles(3);
    check(link_up_o == 0 && page_rcvd_o == 0, "R1", "outputs in reset", link_up_o, 0);
    rst = 0;
    cycles(2);
    check(link_up_o == 0 && speed100_o == 0, "R1", "outputs after reset", link_up_o, 0);

    // R2: exact qualification time
    cur_req = "R2";
    idle_sym_i = 1; lock_i = 1;
    cycles(L);
    check(link_up_o == 0, "R2", "link one edge early", link_up_o, 0);
    cycles(1);
    check(link_up_o == 1 && speed100_o == 1, "R2", "link at 100", link_up_o, 1);
    check(half_duplex_o == 1, "R7", "half duplex at 100", half_duplex_o, 1);
    // R8: sticky bit
    cur_req = "R8";
    cycles(10);
    check(page_rcvd_o == 1, "R8", "sticky held", page_rcvd_o, 1);
    status_rd_i = 1; cycles(1); status_rd_i = 0;
    check(page_rcvd_o == 0, "R8", "cleared by read", page_rcvd_o, 0);

    // R4: runs of exactly the threshold keep the link
    cur_req = "R4";
    idle_pattern(MIN, 1, 4 * WIN);
    check(link_up_o == 1, "R4", "threshold runs keep link", link_up_o, 1);
    // runs one short drop it
    begin
      int waited = 0;
      for (int i = 0; i < 3 * WIN && link_up_o; i++) begin
        idle_sym_i = ((i % MIN) < MIN - 1);
        @(negedge clk);
        waited++;
      end
      check(link_up_o == 0, "R4", "short runs drop link", link_up_o, 0);
      check(waited <= 2 * WIN, "R4", "drop within two windows", waited, 2 * WIN);
    end
    cur_req = "R9";
    lock_i = 0; idle_sym_i = 1;
    cycles(1);
    check(link_up_o == 0, "R9", "down gap after drop", link_up_o, 0);
    cycles(3);

    // R3: lock glitch restarts the count
    cur_req = "R3";
    lock_i = 1; cycles(L - 5);
    lock_i = 0; cycles(1);
    lock_i = 1; cycles(7);
    check(link_up_o == 0, "R3", "no early link after glitch", link_up_o, 0);
    cycles(L);
    check(link_up_o == 1, "R3", "link after full recount", link_up_o, 1);

    // R10: restart clears link and sticky bit
    cur_req = "R10";
    status_rd_i = 1; an_restart_i = 1; lock_i = 0;
    cycles(1);
    an_restart_i = 0; status_rd_i = 0;
    check(link_up_o == 0 && page_rcvd_o == 0, "R10", "restart clears", page_rcvd_o, 0);
    cycles(3);

    // R7: lock ignored without 100 ability
    cur_req = "R7";
    adv_hd100_i = 0; lock_i = 1;
    cycles(2 * L);
    check(link_up_o == 0, "R7", "lock ignored without ability", link_up_o, 0);
    lock_i = 0; adv_hd100_i = 1;
    adv_hd10_i = 0; nlp_i = 1; tx_en_i = 0; rx_dv_i = 0;
    cycles(3 * NLP);
    check(link_up_o == 0, "R7", "pulses ignored without ability", link_up_o, 0);
    nlp_i = 0; adv_hd10_i = 1;
    cycles(2);

    // R6: bursts one short of the filter
    cur_req = "R6";
    for (int b = 0; b < 5; b++) begin
      nlp_i = 1; cycles(NLP - 1);
      nlp_i = 0; cycles(2);
    end
    check(link_up_o == 0, "R6", "short bursts ignored", link_up_o, 0);

    // R5: 10 Mbps path waits for both sides quiet
    cur_req = "R5";
    tx_en_i = 1; rx_dv_i = 1; nlp_i = 1;
    cycles(NLP + 3);
    nlp_i = 0;
    check(link_up_o == 0, "R5", "no link during tx", link_up_o, 0);
    tx_en_i = 0; cycles(4);
    check(link_up_o == 0, "R5", "no link during rx", link_up_o, 0);
    rx_dv_i = 0; cycles(1);
    check(link_up_o == 1 && speed100_o == 0, "R5", "10 Mbps link", speed100_o, 0);
    check(half_duplex_o == 1, "R7", "half duplex at 10", half_duplex_o, 1);
    check(page_rcvd_o == 1, "R8", "sticky set at 10", page_rcvd_o, 1);
    cycles(5);
    restart();
    cycles(2);

    // R11: lock wins over pulses
    cur_req = "R11";
    nlp_i = 1; cycles(NLP - 1);
    lock_i = 1; cycles(L + 2);
    check(link_up_o == 1 && speed100_o == 1, "R11", "100 preferred", speed100_o, 1);
    nlp_i = 0; lock_i = 0;
    cycles(5);
    restart();
    cycles(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule